// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight interrupt request lines into a request register and gives the processor one interrupt line. The line is raised whenever any request bit is set. Each request line has its own seven-bit priority code. Software uses a small word-addressed register bus to find the most urgent request. A plain vector read reports the input number of that request and leaves the request set. An acknowledge read reports the same number and claims the request, which clears its bit.

A write-only clear register cancels any single request by its input number. A read-only identification word returns a fixed version code. Each request line is built as edge-sensitive or level-sensitive, chosen by a parameter bit. An edge-sensitive line sets its bit on a rising edge. A level-sensitive line keeps its bit set for as long as it is held high.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset, every priority code reads 0x5F. The vector and acknowledge registers read 0, and `irq_o` is low.
- R2: Reading byte offset 0x000 returns the version code 0x0006. Writes to that offset change nothing.
- R3: A rising edge on an edge-type input sets its request bit at the clock edge where the high level is first sampled. `irq_o` is high whenever at least one request bit is set.
- R4: Reading offset 0x004 returns, in bits 2..0, the input number of the pending request with the numerically highest priority code. It returns 0 when nothing is pending. The read clears no request bit.
- R5: When pending requests share the highest priority code, the lowest input number is reported.
- R6: Reading offset 0x008 returns the same vector as offset 0x004 and clears that request bit. The vector register then shows the next pending request, or 0. An acknowledge read with nothing pending returns 0 and changes nothing.
- R7: Each completed acknowledge read claims exactly one request, including when the master holds the request across several completions.
- R8: Writing an input number to bits 2..0 of offset 0x00C clears that input's request bit.
- R9: If a request bit is set and cleared in the same cycle, the set wins.
- R10: A level-type input keeps its request bit set while it is high, so a clear does not remove the request.
- R11: The priority code of input n is stored at byte offset 0x100 + 4·n, in bits 6..0. The upper bits read as 0.
- R12: `bus_done` rises one cycle after a request is accepted and lasts one cycle. A request still held in the `bus_done` cycle is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines |
| bus_req | input | 1 | Bus transfer request, held until `bus_done` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_done | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid while `bus_done` is high |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The hardest situation to reach from the ports is a set and a clear of the same request bit landing on one clock edge. The bench reaches it by raising an input line in the same half-cycle in which it starts a clear write for that input. Both then reach the same clock edge.

A second hard case is a master that keeps an acknowledge read pending across several completions. The bench holds the bus request high over three cycles. It then confirms that the two completions claim two different requests, and that the idle cycle between them claims nothing.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_IRQ  = 8;
    localparam int VEC_W    = $clog2(NUM_IRQ);
    localparam int PRIO_W   = 7;
    localparam int DATA_W   = 32;
    localparam int ID_W     = 16;

    localparam logic [PRIO_W-1:0] PRIO_RST = 7'h5F;
    localparam logic [ID_W-1:0]   ID_CODE  = 16'h0006;

    // byte offsets of the register slots
    localparam int OFS_ID        = 'h000;
    localparam int OFS_VEC       = 'h004;
    localparam int OFS_ACK       = 'h008;
    localparam int OFS_CLR       = 'h00C;
    localparam int OFS_PRIO_BASE = 'h100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ID,
        OP_VEC,
        OP_ACK,
        OP_CLR,
        OP_PRIO
    } reg_op_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] idx;
    } vec_t;

    typedef logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_arr_t;

    function automatic logic [DATA_W-1:0] vec_word(input vec_t v);
        return DATA_W'(v.valid ? v.idx : '0);
    endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_vec_pkg::*;
#(
    parameter logic [NUM_IRQ-1:0] TRIG_EDGE = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               clr_en,
    input  logic [VEC_W-1:0]   clr_idx,
    output logic [NUM_IRQ-1:0] pend
);

    logic [NUM_IRQ-1:0] prev_q;
    logic [NUM_IRQ-1:0] set_v;
    logic [NUM_IRQ-1:0] clr_v;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        if (TRIG_EDGE[i]) begin : g_edge
            assign set_v[i] = irq_in[i] & ~prev_q[i];
        end else begin : g_level
            assign set_v[i] = irq_in[i];
        end
        assign clr_v[i] = clr_en && (clr_idx == VEC_W'(i));
    end

    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= set_v | (pend & ~clr_v);
    end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_vec_pkg::*;
(
    input  logic [NUM_IRQ-1:0] pend,
    input  prio_arr_t          prio,
    output vec_t               best
);

    logic [PRIO_W-1:0] best_prio;

    // ascending scan with strict compare: ties go to the lowest index
    always_comb begin
        best      = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (!best.valid || prio[i] > best_prio)) begin
                best.valid = 1'b1;
                best.idx   = VEC_W'(i);
                best_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_done,
    output logic [DATA_W-1:0]  bus_rdata,
    input  vec_t               best,
    output prio_arr_t          prio,
    output logic               clr_en,
    output logic [VEC_W-1:0]   clr_idx
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_ID   = WORD_W'(OFS_ID >> 2);
    localparam logic [WORD_W-1:0] W_VEC  = WORD_W'(OFS_VEC >> 2);
    localparam logic [WORD_W-1:0] W_ACK  = WORD_W'(OFS_ACK >> 2);
    localparam logic [WORD_W-1:0] W_CLR  = WORD_W'(OFS_CLR >> 2);
    localparam logic [WORD_W-1:0] W_PRIO = WORD_W'(OFS_PRIO_BASE >> 2);

    logic              accept;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] rel;
    logic [VEC_W-1:0]  prio_idx;
    reg_op_e           op;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PRIO_W];

    assign accept   = bus_req && !bus_done;
    assign word     = bus_addr[ADDR_W-1:2];
    assign rel      = word - W_PRIO;
    assign prio_idx = rel[VEC_W-1:0];

    always_comb begin
        op = OP_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if      (word == W_ID)               op = OP_ID;
            else if (word == W_VEC)              op = OP_VEC;
            else if (word == W_ACK)              op = OP_ACK;
            else if (word == W_CLR)              op = OP_CLR;
            else if (rel < WORD_W'(NUM_IRQ))     op = OP_PRIO;
        end
    end

    // clear request: either a clear-vector write or a claiming read
    always_comb begin
        clr_en  = 1'b0;
        clr_idx = '0;
        if (accept && bus_wr && op == OP_CLR) begin
            clr_en  = 1'b1;
            clr_idx = bus_wdata[VEC_W-1:0];
        end else if (accept && !bus_wr && op == OP_ACK && best.valid) begin
            clr_en  = 1'b1;
            clr_idx = best.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_done <= 1'b0;
        else     bus_done <= accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (accept && !bus_wr) begin
            unique case (op)
                OP_ID:          bus_rdata <= DATA_W'(ID_CODE);
                OP_VEC, OP_ACK: bus_rdata <= vec_word(best);
                OP_PRIO:        bus_rdata <= DATA_W'(prio[prio_idx]);
                default:        bus_rdata <= '0;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio[i] <= PRIO_RST;
            else if (accept && bus_wr && op == OP_PRIO && prio_idx == VEC_W'(i))
                prio[i] <= bus_wdata[PRIO_W-1:0];
        end
    end

endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
    import irq_vec_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter logic [NUM_IRQ-1:0] TRIG_EDGE = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_done,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    logic [NUM_IRQ-1:0] pend_q;
    prio_arr_t          prio;
    vec_t               best;
    logic [VEC_W-1:0]   arb_idx;
    logic               clr_en;
    logic [VEC_W-1:0]   clr_idx;

    irq_req_latch #(.TRIG_EDGE(TRIG_EDGE)) latch_i (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .pend    (pend_q)
    );

    irq_prio_arb arb_i (
        .pend (pend_q),
        .prio (prio),
        .best (best)
    );

    irq_regfile #(.ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .best      (best),
        .prio      (prio),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

    assign arb_idx = best.idx;
    assign irq_o   = |pend_q;

endmodule

// File: rtl/irq_vec_ctl_chk.sv
module irq_vec_ctl_chk
    import irq_vec_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter logic [NUM_IRQ-1:0] TRIG_EDGE = '1
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic               bus_req,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_done,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_IRQ-1:0] pend,
    input logic [VEC_W-1:0]   arb_idx
);

    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VEC);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFS_ACK);

    // R1: the interrupt line is quiet right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq_o);

    // R12: completion strobe lasts one cycle and follows acceptance
    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        bus_done |=> !bus_done);
    a_r12_done_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done) |=> bus_done);

    // R4: a plain vector read never clears a request
    a_r4_vec_no_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done && !bus_wr && bus_addr == A_VEC)
        |=> (($past(pend) & ~pend) == '0));

    // R6: acknowledge data equals the winner seen at acceptance
    a_r6_ack_data: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done && !bus_wr && bus_addr == A_ACK)
        |=> (bus_rdata[VEC_W-1:0] == $past(arb_idx)));

    // R7: at most one request removed per cycle
    a_r7_one_claim: assert property (@(posedge clk) disable iff (rst)
        $countones($past(pend) & ~pend) <= 1);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        if (TRIG_EDGE[i]) begin : g_edge
            // R3: rising edge sets the request bit
            a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
                $rose(irq_in[i]) |=> pend[i]);
        end else begin : g_level
            // R10: a held level keeps the request bit set
            a_r10_level_holds: assert property (@(posedge clk) disable iff (rst)
                irq_in[i] |=> pend[i]);
        end
    end

endmodule

bind irq_vec_ctl irq_vec_ctl_chk #(.ADDR_W(ADDR_W), .TRIG_EDGE(TRIG_EDGE)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_done  (bus_done),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pend      (pend_q),
    .arb_idx   (arb_idx)
);

// File: tb/irq_vec_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_in = '0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_done;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // input 7 is level-type, the rest are edge-type
    irq_vec_ctl #(.ADDR_W(12), .TRIG_EDGE(8'h7F)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic wr, input logic [11:0] a,
                            input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        do @(negedge clk); while (!bus_done);
        r = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r);
        bus_xfer(1'b0, a, '0, r);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus_xfer(1'b1, a, d, dummy);
    endtask

    task automatic pulse_in(input int k);
        @(negedge clk) irq_in[k] = 1'b1;
        @(negedge clk) irq_in[k] = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        check("R1 irq_o after reset", {31'b0, irq_o}, 0);
        rd(12'h004, r); check("R1 vector after reset", r, 0);
        rd(12'h008, r); check("R1 ack after reset", r, 0);
        rd(12'h100, r); check("R1 prio0 reset", r, 32'h5F);
        rd(12'h11C, r); check("R1 prio7 reset", r, 32'h5F);
    endtask

    task automatic t_id;
        logic [31:0] r;
        rd(12'h000, r); check("R2 id read", r, 32'h0006);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, r); check("R2 id after write", r, 32'h0006);
    endtask

    task automatic t_edge_clear;
        logic [31:0] r;
        pulse_in(2);
        check("R3 irq_o after edge", {31'b0, irq_o}, 1);
        rd(12'h004, r); check("R4 vector input2", r, 2);
        rd(12'h004, r); check("R4 vector read twice", r, 2);
        wr(12'h00C, 32'd2);
        check("R8 irq_o after clear", {31'b0, irq_o}, 0);
        rd(12'h004, r); check("R8 vector after clear", r, 0);
    endtask

    task automatic t_prio_ack;
        logic [31:0] r;
        wr(12'h104, 32'h0000_0020);
        wr(12'h114, 32'hFFFF_FF60);
        rd(12'h114, r); check("R11 prio5 readback", r, 32'h60);
        rd(12'h104, r); check("R11 prio1 readback", r, 32'h20);
        pulse_in(1); pulse_in(3); pulse_in(5);
        rd(12'h004, r); check("R4 highest code wins", r, 5);
        rd(12'h008, r); check("R6 ack returns 5", r, 5);
        rd(12'h004, r); check("R6 next after ack", r, 3);
        rd(12'h008, r); check("R6 ack returns 3", r, 3);
        rd(12'h008, r); check("R6 ack returns 1", r, 1);
        check("R6 irq_o drained", {31'b0, irq_o}, 0);
        rd(12'h008, r); check("R6 ack empty", r, 0);
        check("R6 irq_o after empty ack", {31'b0, irq_o}, 0);
    endtask

    task automatic t_tie;
        logic [31:0] r;
        pulse_in(6); pulse_in(4);
        rd(12'h004, r); check("R5 tie lowest index", r, 4);
        wr(12'h00C, 32'd4);
        rd(12'h004, r); check("R5 remaining after clear", r, 6);
        wr(12'h00C, 32'd6);
        check("R8 irq_o after clears", {31'b0, irq_o}, 0);
    endtask

    task automatic t_held_ack;
        logic [31:0] r;
        pulse_in(2); pulse_in(0);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 12'h008;
        @(negedge clk);
        check("R12 done first", {31'b0, bus_done}, 1);
        check("R7 first ack data", bus_rdata, 0);
        @(negedge clk);
        check("R12 no accept in done cycle", {31'b0, bus_done}, 0);
        @(negedge clk);
        check("R12 done second", {31'b0, bus_done}, 1);
        check("R7 second ack data", bus_rdata, 2);
        bus_req = 1'b0;
        check("R7 both claimed", {31'b0, irq_o}, 0);
        rd(12'h004, r); check("R7 vector empty", r, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] r;
        @(negedge clk);
        irq_in[3] = 1'b1;
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 12'h00C; bus_wdata = 32'd3;
        @(negedge clk);
        bus_req = 1'b0;
        irq_in[3] = 1'b0;
        check("R9 set wins irq_o", {31'b0, irq_o}, 1);
        rd(12'h004, r); check("R9 set wins vector", r, 3);
        wr(12'h00C, 32'd3);
        check("R9 later clear works", {31'b0, irq_o}, 0);
    endtask

    task automatic t_level;
        logic [31:0] r;
        @(negedge clk) irq_in[7] = 1'b1;
        @(negedge clk);
        rd(12'h004, r); check("R10 level pending", r, 7);
        wr(12'h00C, 32'd7);
        rd(12'h004, r); check("R10 clear while high", r, 7);
        check("R10 irq_o held", {31'b0, irq_o}, 1);
        @(negedge clk) irq_in[7] = 1'b0;
        wr(12'h00C, 32'd7);
        rd(12'h004, r); check("R10 clear after release", r, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_id();
        t_edge_clear();
        t_prio_ack();
        t_tie();
        t_held_ack();
        t_set_wins();
        t_level();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule